// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine that sits beside a processor's main datapath. It takes a six-bit function code and two operands, and it works out the full double-width product or the quotient and remainder one bit per clock. The results go into two private registers, HI and LO, rather than into the register file. Two move-from commands read HI or LO back out as a response word. Software never sees the iteration: a read that arrives while an operation is still running simply waits until the result is ready.

Commands enter on a valid/ready channel. A command is taken on any rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while an arithmetic operation runs and while a move-from response is still waiting to be taken. Responses leave on a second valid/ready channel. Once `rsp_valid` rises, it and `rsp_data` stay unchanged until the consumer raises `rsp_ready`, so a consumer that holds `rsp_ready` low stalls the command side too. `busy` is a plain status output.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO both read as zero, `busy` is low and `rsp_valid` is low.
- R2: The function codes (decimal, on `cmd_func`) are: 16 reads HI, 18 reads LO, 24 is a signed multiply, 25 is an unsigned multiply, 26 is a signed divide and 27 is an unsigned divide.
- R3: A signed multiply treats both operands as two's complement. It writes the low half of the 2W-bit product to LO and the high half to HI.
- R4: An unsigned multiply treats both operands as unsigned. It writes the low half of the 2W-bit product to LO and the high half to HI.
- R5: A signed divide of `cmd_rs` by `cmd_rt` writes the quotient, truncated toward zero, to LO. It writes the remainder, which takes the sign of the dividend, to HI. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R6: An unsigned divide writes the unsigned quotient to LO and the unsigned remainder to HI.
- R7: A divide of either kind by zero completes without fault. It leaves LO all ones and HI equal to the dividend exactly as it was given.
- R8: `cmd_ready` is low whenever `busy` is high. After a multiply or divide is accepted, `busy` is high for exactly W+1 cycles, and HI/LO take their new values when it falls.
- R9: A move-from raises `rsp_valid` one cycle after it is accepted, with the HI or LO value on `rsp_data`. Both stay unchanged until a cycle with `rsp_ready` high, and `cmd_ready` stays low meanwhile.
- R10: Any other function code is accepted and has no effect: HI and LO keep their values and no response is produced.
- R11: A move-from presented while an operation is running is held off and then returns the result of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_func | input | 6 | Function code |
| cmd_rs | input | W | First operand (multiplicand / dividend) |
| cmd_rt | input | W | Second operand (multiplier / divisor) |
| busy | output | 1 | Multiply or divide in progress |
| rsp_valid | output | 1 | Move-from result present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | W | HI or LO value |

## Verification
The bench builds the unit with its default width of 32. At that width the operand corners are exact 32-bit values that can be checked against 64-bit reference arithmetic. These corners are the most negative number squared, the most negative number divided by -1, all-ones times all-ones and divides by zero with a negative dividend. The bench also holds back responses on a repeating pattern, so the stall of the command channel behind a pending response is exercised. It issues reads right behind long operations to reach the hold-off case.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [5:0] {
    FN_RD_HI = 6'd16,
    FN_RD_LO = 6'd18,
    FN_MUL_S = 6'd24,
    FN_MUL_U = 6'd25,
    FN_DIV_S = 6'd26,
    FN_DIV_U = 6'd27
  } hilo_fn_e;
endpackage

// File: rtl/hilo_mul_seq.sv
module hilo_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           sgn,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  acc_hi, acc_lo, mcand;
  logic          neg;
  logic [W-1:0]  mag_a, mag_b;
  logic [W:0]    sum;
  logic [2*W-1:0] raw;

  // work on magnitudes, fix the sign at the end
  assign mag_a = (sgn && opa[W-1]) ? (~opa + 1'b1) : opa;
  assign mag_b = (sgn && opb[W-1]) ? (~opb + 1'b1) : opb;
  assign sum   = acc_lo[0] ? ({1'b0, acc_hi} + {1'b0, mcand}) : {1'b0, acc_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
      mcand  <= '0;
      neg    <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      cnt    <= CW'(W);
      acc_hi <= '0;
      acc_lo <= mag_a;
      mcand  <= mag_b;
      neg    <= sgn & (opa[W-1] ^ opb[W-1]);
    end else if (run) begin
      if (cnt != '0) begin
        acc_hi <= sum[W:1];
        acc_lo <= {sum[0], acc_lo[W-1:1]};
        cnt    <= cnt - 1'b1;
      end else begin
        run <= 1'b0;
      end
    end
  end

  assign raw  = {acc_hi, acc_lo};
  assign done = run && (cnt == '0);
  assign prod = neg ? (~raw + 1'b1) : raw;
endmodule

// File: rtl/hilo_div_seq.sv
module hilo_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] remd
);
  localparam int CW = $clog2(W + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, quo, den, dvd_raw;
  logic          neg_q, neg_r, dz;
  logic [W-1:0]  mag_n, mag_d;
  logic [W:0]    sh, diff;

  assign mag_n = (sgn && dvd[W-1]) ? (~dvd + 1'b1) : dvd;
  assign mag_d = (sgn && dvs[W-1]) ? (~dvs + 1'b1) : dvs;
  // restoring step: shift in next dividend bit, try subtract
  assign sh    = {rem, quo[W-1]};
  assign diff  = sh - {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      rem     <= '0;
      quo     <= '0;
      den     <= '0;
      dvd_raw <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      dz      <= 1'b0;
    end else if (start) begin
      run     <= 1'b1;
      cnt     <= CW'(W);
      rem     <= '0;
      quo     <= mag_n;
      den     <= mag_d;
      dvd_raw <= dvd;
      neg_q   <= sgn & (dvd[W-1] ^ dvs[W-1]);
      neg_r   <= sgn & dvd[W-1];
      dz      <= (dvs == '0);
    end else if (run) begin
      if (cnt != '0) begin
        if (!diff[W]) begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= sh[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
      end else begin
        run <= 1'b0;
      end
    end
  end

  assign done = run && (cnt == '0);
  assign quot = dz ? '1 : (neg_q ? (~quo + 1'b1) : quo);
  assign remd = dz ? dvd_raw : (neg_r ? (~rem + 1'b1) : rem);
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [5:0]   cmd_func,
  input  logic [W-1:0] cmd_rs,
  input  logic [W-1:0] cmd_rt,
  output logic         busy,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  logic           busy_q, rsp_v_q;
  logic [W-1:0]   hi_q, lo_q, rsp_q;
  logic           take, is_mul, is_div, is_rd, fn_signed;
  logic           mul_done, div_done;
  logic [2*W-1:0] mul_prod;
  logic [W-1:0]   div_q, div_r;

  assign cmd_ready = !busy_q && !rsp_v_q;
  assign take      = cmd_valid && cmd_ready;
  assign is_mul    = (cmd_func == FN_MUL_S) || (cmd_func == FN_MUL_U);
  assign is_div    = (cmd_func == FN_DIV_S) || (cmd_func == FN_DIV_U);
  assign is_rd     = (cmd_func == FN_RD_HI) || (cmd_func == FN_RD_LO);
  assign fn_signed = (cmd_func == FN_MUL_S) || (cmd_func == FN_DIV_S);

  hilo_mul_seq #(.W(W)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .start(take && is_mul),
    .sgn  (fn_signed),
    .opa  (cmd_rs),
    .opb  (cmd_rt),
    .done (mul_done),
    .prod (mul_prod)
  );

  hilo_div_seq #(.W(W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(take && is_div),
    .sgn  (fn_signed),
    .dvd  (cmd_rs),
    .dvs  (cmd_rt),
    .done (div_done),
    .quot (div_q),
    .remd (div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (take && (is_mul || is_div)) begin
        busy_q <= 1'b1;
      end else if (mul_done) begin
        busy_q <= 1'b0;
        hi_q   <= mul_prod[2*W-1:W];
        lo_q   <= mul_prod[W-1:0];
      end else if (div_done) begin
        busy_q <= 1'b0;
        hi_q   <= div_r;
        lo_q   <= div_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else if (take && is_rd) begin
      rsp_v_q <= 1'b1;
      rsp_q   <= (cmd_func == FN_RD_HI) ? hi_q : lo_q;
    end else if (rsp_v_q && rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [5:0]   cmd_func,
  input logic         busy,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data
);
  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] BUSY_LEN = CW'(W + 1);

  logic [CW-1:0] bcnt;
  logic          acc_arith, acc_rd;

  assign acc_arith = cmd_valid && cmd_ready && (cmd_func >= 6'd24) && (cmd_func <= 6'd27);
  assign acc_rd    = cmd_valid && cmd_ready && ((cmd_func == 6'd16) || (cmd_func == 6'd18));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  // R8: busy run length is exactly W+1 cycles
  always_ff @(posedge clk) begin
    if (rst_n && !busy && bcnt != '0)
      a_r8_busy_length: assert (bcnt == BUSY_LEN);
  end

  a_r8_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_arith |=> busy);

  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r11_no_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_func (cmd_func),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/hilo_muldiv_bench.sv
module hilo_muldiv_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_func = '0;
  logic [W-1:0] cmd_rs = '0, cmd_rt = '0;
  logic         busy, rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_data;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] hi_m = '0, lo_m = '0;
  logic [31:0]  seed = 32'h1234_5677;

  always #4 clk = ~clk;

  hilo_muldiv #(.W(W)) u_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_rs(cmd_rs), .cmd_rt(cmd_rt), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // back-pressure pattern, changed well away from both edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 rsp_ready <= ((cyc % 5) != 2) && ((cyc % 7) != 3);
  end

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard on each response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10 unexpected response got %h expected none", rsp_data);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  function automatic logic [2*W-1:0] ref_mul(input bit sg, input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    if (sg) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic ref_div(input bit sg, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb, tq, tr;
    if (b == 0) begin q = '1; r = a; end
    else if (sg) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      tq = sa / sb; tr = sa % sb;
      q = tq[W-1:0]; r = tr[W-1:0];
    end else begin
      q = a / b; r = a % b;
    end
  endtask

  // driver: presents one command, waits for the handshake, updates model
  task automatic send(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [2*W-1:0] p;
    logic [W-1:0] q, r;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = fn; cmd_rs = a; cmd_rt = b;
    while (!cmd_ready) @(negedge clk);
    case (fn)
      6'd16: begin exp_q.push_back(hi_m); tag_q.push_back({tag, " HI"}); end
      6'd18: begin exp_q.push_back(lo_m); tag_q.push_back({tag, " LO"}); end
      6'd24, 6'd25: begin p = ref_mul(fn == 6'd24, a, b); hi_m = p[2*W-1:W]; lo_m = p[W-1:0]; end
      6'd26, 6'd27: begin ref_div(fn == 6'd26, a, b, q, r); hi_m = r; lo_m = q; end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic op_and_read(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    send(fn, a, b, tag);
    send(6'd16, '0, '0, tag);
    send(6'd18, '0, '0, tag);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    logic [W-1:0] a, b;
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {31'b0, busy}, '0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, '0);
    rst_n = 1'b1;
    send(6'd16, '0, '0, "R1 reset");
    send(6'd18, '0, '0, "R1 reset");

    // R3 signed multiply
    op_and_read(6'd24, 32'd7, -32'sd3, "R3 7*-3");
    op_and_read(6'd24, 32'h8000_0000, 32'h8000_0000, "R3 minneg^2");
    op_and_read(6'd24, '1, '1, "R3 -1*-1");
    op_and_read(6'd24, 32'h7fff_ffff, 32'd2, "R3 max*2");
    // R4 unsigned multiply
    op_and_read(6'd25, '1, '1, "R4 ones*ones");
    op_and_read(6'd25, 32'h1234_5678, 32'h9abc_def0, "R4 mixed");
    // R5 signed divide
    op_and_read(6'd26, -32'sd7, 32'd2, "R5 -7/2");
    op_and_read(6'd26, 32'd7, -32'sd2, "R5 7/-2");
    op_and_read(6'd26, 32'h8000_0000, '1, "R5 minneg/-1");
    op_and_read(6'd26, 32'd100, 32'd7, "R5 100/7");
    // R6 unsigned divide
    op_and_read(6'd27, '1, 32'd3, "R6 ones/3");
    op_and_read(6'd27, 32'd5, 32'd10, "R6 5/10");
    // R7 divide by zero
    op_and_read(6'd26, -32'sd5, '0, "R7 signed /0");
    op_and_read(6'd27, 32'd123, '0, "R7 unsigned /0");

    // R2 / R10: unused codes accepted, no effect, no response
    send(6'd32, 32'hdead_beef, 32'h1, "R10");
    @(negedge clk);
    check("R10 no response", {31'b0, rsp_valid}, '0);
    send(6'd17, 32'h1, 32'h1, "R10");
    send(6'd28, 32'h55, 32'h3, "R10");
    send(6'd16, '0, '0, "R10 HI kept");
    send(6'd18, '0, '0, "R10 LO kept");

    // R8: busy length and cmd_ready low while busy
    send(6'd24, 32'd3, 32'd5, "R8");
    n = 0;
    while (busy) begin
      if (cmd_ready) begin tests++; fails++; $display("FAIL R8 cmd_ready got 1 expected 0 while busy"); end
      n++;
      @(negedge clk);
    end
    check("R8 busy cycles", W'(n), W'(W + 1));
    send(6'd18, '0, '0, "R8 result");

    // R11: read issued right behind a divide waits for it
    send(6'd26, -32'sd1000, 32'd33, "R11");
    send(6'd18, '0, '0, "R11 stall");
    send(6'd16, '0, '0, "R11 stall");

    // R9 plus mixed patterns under back-pressure
    for (int i = 0; i < 24; i++) begin
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = (i % 6 == 5) ? '0 : (seed >> (i % 9));
      case (i % 4)
        0: op_and_read(6'd24, a, b, "R9 R3 sweep");
        1: op_and_read(6'd25, a, b, "R9 R4 sweep");
        2: op_and_read(6'd26, a, b, "R9 R5 sweep");
        default: op_and_read(6'd27, a, b, "R9 R6 sweep");
      endcase
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired, pending %0d expected 0", exp_q.size());
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule